// File: doc/BRIEF.md
# Vector Binary Normalizer

This unit prepares one vector for drawing. It takes a signed X delta and a signed Y delta and shifts both magnitudes left by the same number of places. It keeps shifting until one more shift would push either magnitude into the top bit of the word. A draw-time exponent starts at its largest value and drops by one on every shift. The product of each magnitude and the time value 2^exponent therefore stays constant. The line comes out at the same length, but it is drawn in fewer time units, close to the top speed of the deflection stage.

The caller places the deltas and an optional extra down-scale on the inputs and pulses `start`. The unit then shifts at most once per clock. It raises `done` for exactly one cycle when the result is ready. The signs pass through untouched, to steer the position counters up or down. The extra scale lowers the reported exponent further, which lets short vectors be drawn faster.

Top module: `vec_norm`

## Requirements
- R1: After reset `busy` and `done` are 0, both magnitudes are 0, both sign outputs are 0 and `texp` is 11 (for the default W=12).
- R2: Each magnitude is the absolute value of its delta. Each sign output equals bit W-1 of its delta. The most negative input (-2048) is clamped to a magnitude of 2047.
- R3: Both magnitudes shift left together. Shifting stops as soon as bit W-2 (bit 10) of either magnitude is 1, so bit W-1 of a magnitude is never 1. Example: X=106, Y=14 gives X=1696, Y=224.
- R4: The unit makes one shift per clock. `done` is seen n+1 clocks after the edge that captures `start`, where n is the number of shifts.
- R5: The exponent starts at W-1 (11) and drops by one on every shift. Example: X=106, Y=14 with no extra scale gives `texp`=7.
- R6: `texp` equals the shift-derived exponent minus the `xscale` value captured at start. The result saturates at 0.
- R7: When both deltas are zero, no shift is made, `done` comes after one clock and `texp` equals 11 minus the scale.
- R8: `done` is high for exactly one cycle. A `start` that arrives while `busy` is high is ignored and leaves the running result unchanged.
- R9: Every magnitude from 128 to 255 on a single axis gives the same exponent (8) after three shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a normalization; ignored while busy |
| dx | input | 12 | Signed X delta |
| dy | input | 12 | Signed Y delta |
| xscale | input | 4 | Extra down-scale subtracted from the exponent |
| busy | output | 1 | Normalization in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| mag_x | output | 12 | Normalized X magnitude |
| mag_y | output | 12 | Normalized Y magnitude |
| neg_x | output | 1 | Sign of the X delta |
| neg_y | output | 1 | Sign of the Y delta |
| texp | output | 4 | Draw-time exponent (time = 2^texp) |

## Verification
The stimulus covers the following cases:
- An X-dominant vector and a Y-dominant vector, to show that the stop rule looks at either axis.
- A negative delta, to separate the magnitude path from the sign path.
- A single-unit delta, for the longest shift run.
- The extreme negative value, for the clamp.
- A zero vector, for the case with no shift at all.
- The values 128 and 255, to show that both collapse to the same exponent.

Two scale values, one small and one larger than the exponent, separate plain subtraction from saturation. A start pulse issued in the middle of a run shows whether a busy unit ignores new requests.

// File: rtl/vec_norm.sv
module vec_norm #(
  parameter int W  = 12,
  parameter int EW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  dx,
  input  logic [W-1:0]  dy,
  input  logic [EW-1:0] xscale,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  mag_x,
  output logic [W-1:0]  mag_y,
  output logic          neg_x,
  output logic          neg_y,
  output logic [EW-1:0] texp
);
  localparam int TOP = W - 2;
  localparam logic [EW-1:0] INIT_E = EW'(W - 1);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

  logic [W-1:0]  mx, my;
  logic [EW-1:0] e, sc;
  logic          sx, sy;

  function automatic logic [W-1:0] absval(input logic [W-1:0] v);
    if (v == MOST_NEG) return MOST_POS;
    return v[W-1] ? (~v + 1'b1) : v;
  endfunction

  wire nonzero   = |(mx | my);
  wire can_shift = busy && nonzero && !mx[TOP] && !my[TOP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      mx   <= '0;
      my   <= '0;
      sx   <= 1'b0;
      sy   <= 1'b0;
      e    <= INIT_E;
      sc   <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          mx   <= absval(dx);
          my   <= absval(dy);
          sx   <= dx[W-1];
          sy   <= dy[W-1];
          e    <= INIT_E;
          sc   <= xscale;
        end
      end else if (can_shift) begin
        mx <= mx << 1;
        my <= my << 1;
        e  <= e - 1'b1;
      end else begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  assign mag_x = mx;
  assign mag_y = my;
  assign neg_x = sx;
  assign neg_y = sy;
  assign texp  = (e > sc) ? (e - sc) : '0;

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mag_x[W-1] && !mag_y[W-1]);

  // R3
  stop_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!nonzero || mx[TOP] || my[TOP]));

  // R4
  ratio_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && e != $past(e)) |->
      (mx == ($past(mx) << 1) && my == ($past(my) << 1) && e == $past(e) - 1'b1));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (sx == $past(sx) && sc == $past(sc)));
endmodule

// File: tb/vec_norm_tb_top.sv
`timescale 1ns/1ps
module vec_norm_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] dx = '0, dy = '0;
  logic [3:0]  xscale = '0;
  logic        busy, done, neg_x, neg_y;
  logic [11:0] mag_x, mag_y;
  logic [3:0]  texp;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  vec_norm dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .dx(dx), .dy(dy), .xscale(xscale),
    .busy(busy), .done(done), .mag_x(mag_x), .mag_y(mag_y),
    .neg_x(neg_x), .neg_y(neg_y), .texp(texp)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int x, input int y, input int sc, output int cyc);
    @(negedge clk);
    dx = 12'(x); dy = 12'(y); xscale = 4'(sc); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic vec(input string req, input int x, input int y, input int sc,
                     input int ex, input int ey, input int esx, input int esy,
                     input int ee, input int nshift);
    int cyc;
    run(x, y, sc, cyc);
    chk({req, " mag_x"}, 32'(mag_x), 32'(ex));
    chk({req, " mag_y"}, 32'(mag_y), 32'(ey));
    chk({req, " R2 neg_x"}, 32'(neg_x), 32'(esx));
    chk({req, " R2 neg_y"}, 32'(neg_y), 32'(esy));
    chk({req, " texp"}, 32'(texp), 32'(ee));
    chk({req, " R4 cycles"}, 32'(cyc), 32'(nshift + 1));
    @(negedge clk);
    chk({req, " R8 done pulse"}, 32'(done), 0);
  endtask

  task automatic t_reset();
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 mag_x", 32'(mag_x), 0);
    chk("R1 mag_y", 32'(mag_y), 0);
    chk("R1 signs", 32'({neg_x, neg_y}), 0);
    chk("R1 texp", 32'(texp), 11);
  endtask

  task automatic t_busy_start();
    int cyc;
    @(negedge clk);
    dx = 12'd1; dy = 12'd0; xscale = 4'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    dx = -12'sd5; dy = 12'd5; xscale = 4'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 3;
    while (!done && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    chk("R8 ignored start mag_x", 32'(mag_x), 1024);
    chk("R8 ignored start neg_x", 32'(neg_x), 0);
    chk("R8 ignored start texp", 32'(texp), 1);
    chk("R8 ignored start cycles", 32'(cyc), 11);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    vec("R3 R5 example", 106, 14, 0, 1696, 224, 0, 0, 7, 4);
    vec("R2 negative x", -106, 14, 0, 1696, 224, 1, 0, 7, 4);
    vec("R2 negative y", 3, -700, 0, 6, 1400, 0, 1, 10, 1);
    vec("R3 y dominant", 3, 700, 0, 6, 1400, 0, 0, 10, 1);
    vec("R9 low 128", 128, 0, 0, 1024, 0, 0, 0, 8, 3);
    vec("R9 high 255", 255, 0, 0, 2040, 0, 0, 0, 8, 3);
    vec("R7 zero", 0, 0, 0, 0, 0, 0, 0, 11, 0);
    vec("R7 zero scaled", 0, 0, 2, 0, 0, 0, 0, 9, 0);
    vec("R3 R4 unit", 1, 0, 0, 1024, 0, 0, 0, 1, 10);
    vec("R2 clamp", -2048, 0, 0, 2047, 0, 1, 0, 11, 0);
    vec("R6 scale", 106, 14, 3, 1696, 224, 0, 0, 4, 4);
    vec("R6 saturate", 106, 14, 9, 1696, 224, 0, 0, 0, 4);
    t_busy_start();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule